// File: doc/BRIEF.md
# Linked-List Descriptor Prefetch Controller

This block walks a chain of DMA descriptors held in memory. Software loads the address of the first descriptor and sets the start bit. The block reads each descriptor through a request/response read port and checks the ownership flag. It offers every owned descriptor to a downstream dispatcher over a valid/ready handshake. Once the dispatcher signals that the transfer is finished, the block writes the descriptor back to memory. It then follows the next-pointer to the following descriptor.

Three modes change what happens at the end of a chain. In ownership polling, the block waits a programmable number of cycles and re-reads a descriptor it does not own, until software hands that descriptor over. In park mode, write-back leaves the ownership flag set, so a circular chain replays without end. A software-started reset sequence drains outstanding memory traffic and returns the block to idle. Completion interrupts are masked before they are latched, so an interrupt that arrives while the mask is off is lost.

Top module: `desc_prefetcher`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0, and no memory request or dispatcher offer is active.
- R2: CSR word 0 is control: bit 0 start, bit 1 poll enable, bit 2 reset, bit 3 interrupt enable, bit 4 park. Bits 31:5 read 0. Start and reset are write-1-to-set, so writing 0 to them has no effect. Word 1 is the poll interval (low POLL_W bits), word 2 is status (bit 0 IRQ), and word 3 is the chain head address.
- R3: A descriptor is 64 bits: bits 31:0 hold the next pointer, bits 47:32 hold the length, bit 62 is end-of-chain and bit 63 is owned. When start is set, the block reads from the head and follows the next pointers. Each owned descriptor is offered in chain order, with its address and length. The offer is held stable until `dsp_ready`.
- R4: With polling off, start clears after an end-of-chain descriptor has been written back. Start also clears when a fetched descriptor is not owned, and that descriptor is never offered.
- R5: With polling on, an unowned descriptor or an end-of-chain write-back leads to a wait of at least the poll interval in cycles. The block then re-reads the descriptor and continues once it is owned. Start stays 1 throughout.
- R6: If poll enable is cleared while the block runs, the block stops and clears start at the next unowned descriptor it reads.
- R7: After `dsp_done`, the descriptor is written back unchanged except for bit 63. Bit 63 is cleared when park is off and kept at 1 when park is on.
- R8: With park on, a circular chain keeps running. Clearing park while it runs causes later write-backs to release ownership, so the chain then stops by itself.
- R9: Writing 1 to the reset bit starts a reset sequence. During the sequence no memory request is issued, and the sequence waits for any outstanding response. At the end, hardware clears both the reset bit and start, and the block can then be started again.
- R10: Each write-back acknowledge is a completion event. The event sets status IRQ only if interrupt enable is 1 in that cycle. Writing 1 to status bit 0 clears IRQ, and `irq` equals the latched bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr | input | 1 | CSR write strobe |
| csr_word | input | 2 | CSR word index |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data for `csr_word` |
| mem_rd_req | output | 1 | Descriptor read request, one cycle |
| mem_rd_addr | output | ADDR_W | Descriptor read address |
| mem_rd_valid | input | 1 | Read response strobe |
| mem_rd_data | input | 64 | Read response descriptor |
| mem_wr_req | output | 1 | Write-back request, one cycle |
| mem_wr_addr | output | ADDR_W | Write-back address |
| mem_wr_data | output | 64 | Write-back descriptor |
| mem_wr_ack | input | 1 | Write-back acknowledge |
| dsp_valid | output | 1 | Descriptor offered to dispatcher |
| dsp_ready | input | 1 | Dispatcher accepts offer |
| dsp_addr | output | ADDR_W | Address of offered descriptor |
| dsp_len | output | LEN_W | Length of offered descriptor |
| dsp_done | input | 1 | Dispatcher finished the accepted descriptor |
| irq | output | 1 | Latched completion interrupt |

## Verification
The bench starts a reset while a descriptor read is still outstanding. A design that skipped the drain would leave reset set forever, would issue a fresh read during the sequence, or would keep the start bit at 1.

It runs a circular chain in park mode and checks that ownership survives every write-back. It then clears park mid-run and expects the chain to stop. A design that read park only at start-up would loop forever, and one that ignored it would stop after a single lap.

With polling on, it measures the spacing between re-reads of an unowned descriptor, hands the descriptor over during the wait, and then clears poll enable. A design that stopped at the end of the chain, or that polled without a delay, or that never stopped after poll enable was cleared, shows up in those counts.

It also completes descriptors while the interrupt enable is 0 and then sets the enable. A design that held the event pending would raise `irq` at that point.

// File: rtl/pfx_pkg.sv
`timescale 1ns/1ps
package pfx_pkg;
   localparam int DESC_W  = 64;
   localparam int OWN_POS = 63;
   localparam int EOL_POS = 62;
   localparam int LEN_LSB = 32;

   typedef enum logic [3:0] {
      ST_IDLE, ST_FETCH, ST_RD_WAIT, ST_OFFER, ST_BUSY,
      ST_WB, ST_WB_WAIT, ST_NAP, ST_DRAIN
   } pf_state_e;

   typedef struct packed {
      logic park;
      logic gie;
      logic rst;
      logic poll_en;
      logic run;
   } pf_ctrl_t;
endpackage

// File: rtl/pfx_csr.sv
`timescale 1ns/1ps
module pfx_csr import pfx_pkg::*; #(
   parameter int ADDR_W = 32,
   parameter int POLL_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_wr,
   input  logic [1:0]        csr_word,
   input  logic [31:0]       csr_wdata,
   output logic [31:0]       csr_rdata,
   output pf_ctrl_t          ctrl,
   output logic [ADDR_W-1:0] head,
   output logic [POLL_W-1:0] poll_ival,
   input  logic              hw_run_clr,
   input  logic              hw_rst_done,
   input  logic              irq_evt,
   output logic              irq
);
   logic wr_ctl, wr_ival, wr_sts, wr_head;
   logic [31:0] ival_ext, head_ext;

   assign wr_ctl  = csr_wr && (csr_word == 2'd0);
   assign wr_ival = csr_wr && (csr_word == 2'd1);
   assign wr_sts  = csr_wr && (csr_word == 2'd2);
   assign wr_head = csr_wr && (csr_word == 2'd3);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl      <= '0;
         head      <= '0;
         poll_ival <= '0;
         irq       <= 1'b0;
      end else begin
         if (wr_ctl) begin
            ctrl.poll_en <= csr_wdata[1];
            ctrl.gie     <= csr_wdata[3];
            ctrl.park    <= csr_wdata[4];
         end
         // reset completion beats a software start; a start beats a hardware stop
         if (hw_rst_done)                    ctrl.run <= 1'b0;
         else if (wr_ctl && csr_wdata[0])    ctrl.run <= 1'b1;
         else if (hw_run_clr)                ctrl.run <= 1'b0;
         if (wr_ctl && csr_wdata[2])         ctrl.rst <= 1'b1;
         else if (hw_rst_done)               ctrl.rst <= 1'b0;
         if (irq_evt && ctrl.gie)            irq <= 1'b1;
         else if (wr_sts && csr_wdata[0])    irq <= 1'b0;
         if (wr_ival) poll_ival <= csr_wdata[POLL_W-1:0];
         if (wr_head) head      <= csr_wdata[ADDR_W-1:0];
      end
   end

   always_comb begin
      ival_ext = '0;
      ival_ext[POLL_W-1:0] = poll_ival;
      head_ext = '0;
      head_ext[ADDR_W-1:0] = head;
      case (csr_word)
         2'd0:    csr_rdata = {27'd0, ctrl};
         2'd1:    csr_rdata = ival_ext;
         2'd2:    csr_rdata = {31'd0, irq};
         default: csr_rdata = head_ext;
      endcase
   end
endmodule

// File: rtl/pfx_nap.sv
`timescale 1ns/1ps
module pfx_nap #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] ival,
   output logic         expired
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= ival;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/pfx_engine.sv
`timescale 1ns/1ps
module pfx_engine import pfx_pkg::*; #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  pf_ctrl_t          ctrl,
   input  logic [ADDR_W-1:0] head,
   output logic              mem_rd_req,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rd_valid,
   input  logic [DESC_W-1:0] mem_rd_data,
   output logic              mem_wr_req,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [DESC_W-1:0] mem_wr_data,
   input  logic              mem_wr_ack,
   output logic              dsp_valid,
   input  logic              dsp_ready,
   output logic [ADDR_W-1:0] dsp_addr,
   output logic [LEN_W-1:0]  dsp_len,
   input  logic              dsp_done,
   output logic              nap_load,
   input  logic              nap_done,
   output logic              hw_run_clr,
   output logic              hw_rst_done,
   output logic              irq_evt
);
   pf_state_e         state, state_n;
   logic [ADDR_W-1:0] ptr, ptr_n;
   logic [DESC_W-1:0] desc, desc_n;
   logic              rd_out, wr_out;
   logic              rd_busy, wr_busy;

   assign rd_busy = rd_out && !mem_rd_valid;
   assign wr_busy = wr_out && !mem_wr_ack;

   assign mem_rd_req  = (state == ST_FETCH) && !ctrl.rst;
   assign mem_rd_addr = ptr;
   assign mem_wr_req  = (state == ST_WB) && !ctrl.rst;
   assign mem_wr_addr = ptr;
   assign dsp_valid   = (state == ST_OFFER) && !ctrl.rst;
   assign dsp_addr    = ptr;
   assign dsp_len     = desc[LEN_LSB +: LEN_W];

   always_comb begin
      mem_wr_data          = desc;
      mem_wr_data[OWN_POS] = ctrl.park;
   end

   always_comb begin
      state_n     = state;
      ptr_n       = ptr;
      desc_n      = desc;
      nap_load    = 1'b0;
      hw_run_clr  = 1'b0;
      hw_rst_done = 1'b0;
      irq_evt     = 1'b0;
      if (ctrl.rst && state != ST_DRAIN) begin
         state_n = ST_DRAIN;
      end else begin
         case (state)
            ST_IDLE: if (ctrl.run) begin
               ptr_n   = head;
               state_n = ST_FETCH;
            end
            ST_FETCH: state_n = ST_RD_WAIT;
            ST_RD_WAIT: if (mem_rd_valid) begin
               desc_n = mem_rd_data;
               if (mem_rd_data[OWN_POS]) state_n = ST_OFFER;
               else if (ctrl.poll_en) begin
                  state_n  = ST_NAP;
                  nap_load = 1'b1;
               end else begin
                  state_n    = ST_IDLE;
                  hw_run_clr = 1'b1;
               end
            end
            ST_OFFER: if (dsp_ready) state_n = ST_BUSY;
            ST_BUSY:  if (dsp_done)  state_n = ST_WB;
            ST_WB:    state_n = ST_WB_WAIT;
            ST_WB_WAIT: if (mem_wr_ack) begin
               irq_evt = 1'b1;
               ptr_n   = desc[ADDR_W-1:0];
               if (!desc[EOL_POS]) state_n = ST_FETCH;
               else if (ctrl.poll_en) begin
                  state_n  = ST_NAP;
                  nap_load = 1'b1;
               end else begin
                  state_n    = ST_IDLE;
                  hw_run_clr = 1'b1;
               end
            end
            ST_NAP: if (nap_done) state_n = ST_FETCH;
            ST_DRAIN: if (!rd_busy && !wr_busy) begin
               state_n     = ST_IDLE;
               hw_rst_done = 1'b1;
            end
            default: state_n = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         ptr    <= '0;
         desc   <= '0;
         rd_out <= 1'b0;
         wr_out <= 1'b0;
      end else begin
         state <= state_n;
         ptr   <= ptr_n;
         desc  <= desc_n;
         if (mem_rd_req)        rd_out <= 1'b1;
         else if (mem_rd_valid) rd_out <= 1'b0;
         if (mem_wr_req)        wr_out <= 1'b1;
         else if (mem_wr_ack)   wr_out <= 1'b0;
      end
   end
endmodule

// File: rtl/desc_prefetcher.sv
`timescale 1ns/1ps
module desc_prefetcher import pfx_pkg::*; #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 16,
   parameter int POLL_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_wr,
   input  logic [1:0]        csr_word,
   input  logic [31:0]       csr_wdata,
   output logic [31:0]       csr_rdata,
   output logic              mem_rd_req,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rd_valid,
   input  logic [63:0]       mem_rd_data,
   output logic              mem_wr_req,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [63:0]       mem_wr_data,
   input  logic              mem_wr_ack,
   output logic              dsp_valid,
   input  logic              dsp_ready,
   output logic [ADDR_W-1:0] dsp_addr,
   output logic [LEN_W-1:0]  dsp_len,
   input  logic              dsp_done,
   output logic              irq
);
   localparam int MAX_LEN_W = EOL_POS - LEN_LSB;

   generate
      if (ADDR_W < 4 || ADDR_W > LEN_LSB) begin : g_bad_addr
         $error("ADDR_W must lie in 4..32");
      end
      if (LEN_W < 1 || LEN_W > MAX_LEN_W) begin : g_bad_len
         $error("LEN_W must lie in 1..30");
      end
      if (POLL_W < 1 || POLL_W > 32) begin : g_bad_poll
         $error("POLL_W must lie in 1..32");
      end
   endgenerate

   pf_ctrl_t          ctl_q;
   logic [ADDR_W-1:0] head_q;
   logic [POLL_W-1:0] ival_q;
   logic              nap_load, nap_done;
   logic              hw_run_clr, hw_rst_done, irq_evt;
   logic              ctl_run, ctl_rst, ctl_gie;

   assign ctl_run = ctl_q.run;
   assign ctl_rst = ctl_q.rst;
   assign ctl_gie = ctl_q.gie;

   pfx_csr #(.ADDR_W(ADDR_W), .POLL_W(POLL_W)) i_csr (
      .clk, .rst_n, .csr_wr, .csr_word, .csr_wdata, .csr_rdata,
      .ctrl(ctl_q), .head(head_q), .poll_ival(ival_q),
      .hw_run_clr, .hw_rst_done, .irq_evt, .irq
   );

   pfx_nap #(.W(POLL_W)) i_nap (
      .clk, .rst_n, .load(nap_load), .ival(ival_q), .expired(nap_done)
   );

   pfx_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_eng (
      .clk, .rst_n, .ctrl(ctl_q), .head(head_q),
      .mem_rd_req, .mem_rd_addr, .mem_rd_valid, .mem_rd_data,
      .mem_wr_req, .mem_wr_addr, .mem_wr_data, .mem_wr_ack,
      .dsp_valid, .dsp_ready, .dsp_addr, .dsp_len, .dsp_done,
      .nap_load, .nap_done, .hw_run_clr, .hw_rst_done, .irq_evt
   );
endmodule

// File: rtl/pfx_chk.sv
`timescale 1ns/1ps
module pfx_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dsp_valid,
   input logic              dsp_ready,
   input logic [ADDR_W-1:0] dsp_addr,
   input logic              mem_rd_req,
   input logic              mem_wr_req,
   input logic              irq,
   input logic              ctl_run,
   input logic              ctl_rst,
   input logic              ctl_gie
);
   // R3
   offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dsp_valid && !dsp_ready |=> (dsp_valid && $stable(dsp_addr)) || ctl_rst);

   // R4
   offer_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dsp_valid |-> ctl_run);

   // R9
   drain_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rst |-> !mem_rd_req && !mem_wr_req);

   // R9
   reset_stops_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctl_rst) |-> !ctl_run);

   // R10
   irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(ctl_gie));
endmodule

bind desc_prefetcher pfx_chk #(.ADDR_W(ADDR_W)) i_pfx_chk (
   .clk, .rst_n, .dsp_valid, .dsp_ready, .dsp_addr, .mem_rd_req,
   .mem_wr_req, .irq, .ctl_run, .ctl_rst, .ctl_gie
);

// File: tb/test_desc_prefetcher.sv
`timescale 1ns/1ps
module test_desc_prefetcher;
   localparam int AW = 32, LW = 16, PW = 16, LAT = 4, DONE_LAT = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          csr_wr = 1'b0;
   logic [1:0]    csr_word = '0;
   logic [31:0]   csr_wdata = '0;
   logic [31:0]   csr_rdata;
   logic          mem_rd_req, mem_wr_req;
   logic [AW-1:0] mem_rd_addr, mem_wr_addr;
   logic          mem_rd_valid = 1'b0, mem_wr_ack = 1'b0;
   logic [63:0]   mem_rd_data = '0;
   logic [63:0]   mem_wr_data;
   logic          dsp_valid, dsp_ready = 1'b0, dsp_done = 1'b0;
   logic [AW-1:0] dsp_addr;
   logic [LW-1:0] dsp_len;
   logic          irq;

   always #2.5 clk = ~clk;

   desc_prefetcher #(.ADDR_W(AW), .LEN_W(LW), .POLL_W(PW)) i_desc_prefetcher (
      .clk, .rst_n, .csr_wr, .csr_word, .csr_wdata, .csr_rdata,
      .mem_rd_req, .mem_rd_addr, .mem_rd_valid, .mem_rd_data,
      .mem_wr_req, .mem_wr_addr, .mem_wr_data, .mem_wr_ack,
      .dsp_valid, .dsp_ready, .dsp_addr, .dsp_len, .dsp_done, .irq
   );

   int checks = 0, errors = 0, cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   logic [63:0] mem [0:31];
   int rd_cnt = 0, wr_cnt = 0, n_rd = 0;
   int rd_idx = 0, wr_idx = 0;
   logic [63:0] wr_buf = '0;
   logic [AW-1:0] watch = '1;
   int n_watch = 0, t_last = 0, t_prev = 0;
   int rdy_gap = 0, gap_cnt = 0, dn_cnt = 0, n_disp = 0;
   logic [AW-1:0] cap_addr = '0;
   logic [LW-1:0] cap_len = '0;
   logic [AW-1:0] disp_addr [0:63];
   logic [LW-1:0] disp_len  [0:63];

   function automatic logic [63:0] mk(input logic [31:0] nxt, input logic [15:0] len,
                                      input logic eol, input logic own);
      mk = {own, eol, 14'd0, len, nxt};
   endfunction

   // memory responder
   initial begin
      forever begin
         @(negedge clk);
         mem_rd_valid = 1'b0;
         mem_wr_ack   = 1'b0;
         if (rd_cnt != 0) begin
            rd_cnt--;
            if (rd_cnt == 0) begin
               mem_rd_valid = 1'b1;
               mem_rd_data  = mem[rd_idx];
            end
         end
         if (wr_cnt != 0) begin
            wr_cnt--;
            if (wr_cnt == 0) begin
               mem[wr_idx] = wr_buf;
               mem_wr_ack  = 1'b1;
            end
         end
         if (mem_rd_req) begin
            rd_cnt = LAT;
            rd_idx = int'(mem_rd_addr[7:3]);
            n_rd++;
            if (mem_rd_addr == watch) begin
               n_watch++;
               t_prev = t_last;
               t_last = cyc;
            end
         end
         if (mem_wr_req) begin
            wr_cnt = LAT;
            wr_idx = int'(mem_wr_addr[7:3]);
            wr_buf = mem_wr_data;
         end
      end
   end

   // dispatcher model
   initial begin
      forever begin
         @(negedge clk);
         dsp_done = 1'b0;
         if (dn_cnt != 0) begin
            dn_cnt--;
            if (dn_cnt == 0) dsp_done = 1'b1;
         end
         if (dsp_ready) begin
            disp_addr[n_disp % 64] = cap_addr;
            disp_len[n_disp % 64]  = cap_len;
            n_disp++;
            dsp_ready = 1'b0;
            dn_cnt    = DONE_LAT;
         end else if (dsp_valid) begin
            if (gap_cnt >= rdy_gap) begin
               dsp_ready = 1'b1;
               cap_addr  = dsp_addr;
               cap_len   = dsp_len;
               gap_cnt   = 0;
            end else gap_cnt++;
         end
      end
   end

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      #(5.0 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, actual=hung expected=finished");
      summary();
      $finish;
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_true(input string req, input bit ok, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic csr_write(input logic [1:0] w, input logic [31:0] d);
      @(negedge clk);
      csr_word  = w;
      csr_wdata = d;
      csr_wr    = 1'b1;
      @(negedge clk);
      csr_wr    = 1'b0;
   endtask

   task automatic csr_read(input logic [1:0] w, output logic [31:0] d);
      @(negedge clk);
      csr_word = w;
      #1;
      d = csr_rdata;
   endtask

   task automatic wait_run_low(input string req);
      logic [31:0] v = '1;
      bit low = 1'b0;
      for (int k = 0; k < 4000 && !low; k++) begin
         csr_read(2'd0, v);
         if (!v[0]) low = 1'b1;
      end
      chk(req, {63'd0, v[0]}, 64'd0);
   endtask

   task automatic wait_disp(input int target, input string req);
      for (int k = 0; k < 4000 && n_disp < target; k++) @(negedge clk);
      chk_true(req, n_disp >= target, n_disp, target);
   endtask

   task automatic load_chain();
      mem[1] = mk(32'h10, 16'h11, 1'b0, 1'b1);
      mem[2] = mk(32'h18, 16'h22, 1'b0, 1'b1);
      mem[3] = mk(32'h08, 16'h33, 1'b1, 1'b1);
   endtask

   task automatic t_reset_state();
      logic [31:0] v;
      for (int w = 0; w < 4; w++) begin
         csr_read(w[1:0], v);
         chk("R1 csr word after reset", v, 0);
      end
      chk("R1 irq after reset", irq, 0);
      chk("R1 no activity after reset", {dsp_valid, mem_rd_req, mem_wr_req}, 0);
   endtask

   task automatic t_csr_layout();
      logic [31:0] v;
      csr_write(2'd0, 32'hFFFF_FFFA);
      csr_read(2'd0, v);
      chk("R2 control readback, upper bits zero, W1S untouched", v, 32'h1A);
      csr_write(2'd0, 32'h0);
      csr_read(2'd0, v);
      chk("R2 control cleared", v, 0);
      csr_write(2'd1, 32'h1234_5678);
      csr_read(2'd1, v);
      chk("R2 poll interval width", v, 32'h5678);
      csr_write(2'd3, 32'h0000_0108);
      csr_read(2'd3, v);
      chk("R2 head readback", v, 32'h108);
   endtask

   task automatic t_basic_chain();
      logic [31:0] v;
      int base;
      load_chain();
      base    = n_disp;
      rdy_gap = 2;
      csr_write(2'd3, 32'h08);
      csr_write(2'd0, 32'h8);
      csr_write(2'd0, 32'h9);
      wait_run_low("R4 start clears after end of chain");
      chk("R4 three descriptors offered", n_disp - base, 3);
      chk("R3 order first",  disp_addr[base % 64], 32'h08);
      chk("R3 order second", disp_addr[(base + 1) % 64], 32'h10);
      chk("R3 order third",  disp_addr[(base + 2) % 64], 32'h18);
      chk("R3 length second", disp_len[(base + 1) % 64], 16'h22);
      chk("R3 length third",  disp_len[(base + 2) % 64], 16'h33);
      chk("R7 write-back releases, fields kept", mem[1], mk(32'h10, 16'h11, 1'b0, 1'b0));
      chk("R7 write-back last", mem[3], mk(32'h08, 16'h33, 1'b1, 1'b0));
      chk("R10 irq latched with enable", irq, 1);
      csr_read(2'd2, v);
      chk("R10 status bit", v, 1);
      csr_write(2'd2, 32'h1);
      csr_read(2'd2, v);
      chk("R10 status W1C", {v[0], irq}, 2'b00);
      rdy_gap = 0;
   endtask

   task automatic t_unowned_stop_and_mask();
      logic [31:0] v;
      int base;
      mem[1] = mk(32'h10, 16'h5, 1'b0, 1'b1);
      mem[2] = mk(32'h18, 16'h6, 1'b0, 1'b0);
      base = n_disp;
      csr_write(2'd0, 32'h1);
      wait_run_low("R4 start clears at unowned");
      chk("R4 unowned never offered", n_disp - base, 1);
      chk("R10 masked completion not latched", irq, 0);
      csr_write(2'd0, 32'h8);
      repeat (3) @(negedge clk);
      csr_read(2'd2, v);
      chk("R10 masked event lost after enable", {v[0], irq}, 2'b00);
      csr_write(2'd0, 32'h0);
   endtask

   task automatic t_w1s_run();
      logic [31:0] v;
      int base;
      load_chain();
      base    = n_disp;
      rdy_gap = 20;
      csr_write(2'd0, 32'h1);
      repeat (10) @(negedge clk);
      csr_write(2'd0, 32'h0);
      csr_read(2'd0, v);
      chk("R2 writing 0 to start has no effect", v, 32'h1);
      wait_run_low("R2 chain finishes after write of 0");
      chk("R2 all offered despite write of 0", n_disp - base, 3);
      rdy_gap = 0;
   endtask

   task automatic t_park();
      logic [31:0] v;
      int base;
      mem[4] = mk(32'h28, 16'h40, 1'b0, 1'b1);
      mem[5] = mk(32'h20, 16'h50, 1'b0, 1'b1);
      base = n_disp;
      csr_write(2'd3, 32'h20);
      csr_write(2'd0, 32'h11);
      wait_disp(base + 5, "R8 circular chain keeps running in park");
      chk("R7 park keeps ownership A", mem[4], mk(32'h28, 16'h40, 1'b0, 1'b1));
      chk("R7 park keeps ownership B", mem[5], mk(32'h20, 16'h50, 1'b0, 1'b1));
      csr_read(2'd0, v);
      chk("R8 start still set in park", v[0], 1);
      csr_write(2'd0, 32'h0);
      wait_run_low("R8 chain stops after park cleared");
      chk("R8 ownership released after park cleared", {mem[4][63], mem[5][63]}, 2'b00);
   endtask

   task automatic t_poll();
      logic [31:0] v;
      int base, rd_snap;
      mem[6] = mk(32'h38, 16'h6, 1'b1, 1'b1);
      mem[7] = mk(32'h40, 16'h7, 1'b1, 1'b0);
      mem[8] = mk(32'h48, 16'h8, 1'b1, 1'b0);
      watch   = 32'h38;
      n_watch = 0;
      base    = n_disp;
      csr_write(2'd1, 32'd20);
      csr_write(2'd3, 32'h30);
      csr_write(2'd0, 32'h3);
      wait_disp(base + 1, "R5 first descriptor offered");
      repeat (200) @(negedge clk);
      csr_read(2'd0, v);
      chk("R5 start stays set while polling", v[0], 1);
      chk_true("R5 unowned descriptor re-read", n_watch >= 3, n_watch, 3);
      chk_true("R5 re-read spacing at least interval", (t_last - t_prev) >= 20,
               t_last - t_prev, 20);
      mem[7] = mk(32'h40, 16'h7, 1'b1, 1'b1);
      wait_disp(base + 2, "R5 resumes when owned");
      chk("R5 resumed descriptor", disp_addr[(base + 1) % 64], 32'h38);
      repeat (20) @(negedge clk);
      csr_read(2'd0, v);
      chk("R5 start set after resume", v[0], 1);
      rd_snap = n_disp;
      csr_write(2'd0, 32'h0);
      wait_run_low("R6 stops once poll enable cleared");
      chk("R6 nothing more offered", n_disp - rd_snap, 0);
      watch = '1;
   endtask

   task automatic t_reset_seq();
      logic [31:0] v;
      int base, rd_snap;
      bit seen = 1'b0;
      load_chain();
      base = n_disp;
      csr_write(2'd3, 32'h08);
      csr_write(2'd0, 32'h1);
      for (int k = 0; k < 200 && !seen; k++) begin
         @(negedge clk);
         if (mem_rd_req) seen = 1'b1;
      end
      csr_write(2'd0, 32'h4);
      csr_read(2'd0, v);
      chk("R9 reset bit held while response outstanding", v[2], 1);
      rd_snap = n_rd;
      for (int k = 0; k < 100 && v[2]; k++) csr_read(2'd0, v);
      chk("R9 reset and start cleared", v[2:0] & 3'b101, 0);
      chk("R9 no request during reset", n_rd - rd_snap, 0);
      chk("R9 nothing offered", {31'd0, dsp_valid, n_disp - base}, 0);
      csr_write(2'd0, 32'h1);
      wait_run_low("R9 restart after reset");
      chk("R9 full chain after restart", n_disp - base, 3);
   endtask

   initial begin
      for (int i = 0; i < 32; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_csr_layout();
      t_basic_chain();
      t_unowned_stop_and_mask();
      t_w1s_run();
      t_park();
      t_poll();
      t_reset_seq();
      summary();
      $finish;
   end
endmodule